// File: doc/BRIEF.md
# Wide-frame to word serializer

The block takes one wide input frame per frame period and emits it as a burst of narrower tagged words on a clock that runs seven times faster than the frame rate. With the default parameters a frame is 227 bits: 224 payload bits and 3 error flags. The payload leaves as seven 32-bit slices. Each slice is widened to 36 bits by a 4-bit tag built from the frame's error flags, so that every word downstream carries the error state of the frame it came from.

A one-cycle sync strobe in the fast clock domain marks the cycle in which the frame input is valid. The block captures the frame on that strobe. It then drives a valid strobe for the seven words and a first-word strobe on the opening word. A new sync strobe always wins: it reloads the frame and restarts at the first slice, even in the middle of a burst. One instance serves one link.

Top module: `frame_serializer`

## Requirements
- R1: Frame layout: bits 223..0 of `frame_in` are the payload. Bit 226 is the CRC error flag, bit 225 the disparity error flag and bit 224 the not-in-table flag.
- R2: Each output word is 36 bits. Bits 35..32 hold the tag {0, CRC, disparity, not-in-table} and bits 31..0 hold data, so bit 35 is always 0.
- R3: Within a burst, word k (k = 0..6) carries payload bits [32k+31:32k]. The least significant slice goes first and the words follow on consecutive cycles.
- R4: When `frame_sync_in` is sampled high on a clock edge, word 0 of that frame is on the outputs from that edge until the next one.
- R5: Without a further sync, `word_valid` stays high for exactly 7 consecutive cycles per frame and then drops.
- R6: `word_first` is high only while word 0 is presented, and never without `word_valid`.
- R7: A sync strobe during a burst abandons the old frame. The next cycle shows word 0 of the new frame, with `word_first` high.
- R8: While no burst is running, `word_valid` and `word_first` are 0 and `word_data` is all zeros.
- R9: After reset, the outputs are in the idle state of R8.
- R10: Changes on `frame_in` while `frame_sync_in` is low have no effect on the words of a burst that is already running.
- R11: A sync strobe in the cycle that presents word 6 makes the next frame's word 0 follow at once, with no idle cycle between the bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock (seven times the frame rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync_in | input | 1 | One-cycle strobe: frame_in is valid |
| frame_in | input | 227 | Payload in bits 223..0, error flags in bits 226..224 |
| word_valid | output | 1 | Output word is valid |
| word_first | output | 1 | Output word is word 0 of a frame |
| word_data | output | 36 | Tag in bits 35..32, data in bits 31..0 |

## Verification
The bench builds the block with its default parameters: 32-bit words, seven words per frame and three error flags. This makes the full 227-bit frame, all seven slice positions and each flag's own tag bit observable. Table frames use a distinct value in every slice and a different flag pattern each, so any swap of word order or flag position shows up in the data. Directed runs cover a restart in the middle of a burst, a sync on the last word, and frame changes without a sync.

// File: rtl/frame_serializer_pkg.sv
package frame_serializer_pkg;
  localparam int unsigned DEF_WORD_W  = 32;
  localparam int unsigned DEF_N_WORDS = 7;
  localparam int unsigned DEF_FLAG_W  = 3;

  // lowest payload bit of slice k
  function automatic int unsigned slice_base(input int unsigned k, input int unsigned w);
    return k * w;
  endfunction

  // total input frame width for a given geometry
  function automatic int unsigned frame_width(input int unsigned w, input int unsigned n,
                                              input int unsigned f);
    return w * n + f;
  endfunction
endpackage

// File: rtl/frame_hold.sv
module frame_hold #(
  parameter int unsigned FRAME_W = 227
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  output logic [FRAME_W-1:0] frame_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    frame_q <= '0;
    else if (load) frame_q <= frame_in;
  end
endmodule

// File: rtl/word_sequencer.sv
module word_sequencer #(
  parameter int unsigned N_WORDS = 7,
  localparam int unsigned IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             active,
  output logic [IDX_W-1:0] idx,
  output logic             at_last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

  assign at_last = active && (idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (at_last) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (active) begin
      idx    <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/word_assembler.sv
module word_assembler
  import frame_serializer_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned N_WORDS = 7,
  parameter int unsigned FLAG_W  = 3,
  localparam int unsigned FRAME_W = frame_width(WORD_W, N_WORDS, FLAG_W),
  localparam int unsigned TAG_W   = FLAG_W + 1,
  localparam int unsigned OUT_W   = TAG_W + WORD_W,
  localparam int unsigned IDX_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic [FRAME_W-1:0] frame_q,
  input  logic               active,
  input  logic [IDX_W-1:0]   idx,
  output logic [OUT_W-1:0]   word
);
  localparam int unsigned PAY_W = WORD_W * N_WORDS;

  logic [WORD_W-1:0] slices [N_WORDS];
  logic [TAG_W-1:0]  tag;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_slice
    assign slices[g] = frame_q[slice_base(g, WORD_W) +: WORD_W];
  end

  assign tag = {1'b0, frame_q[PAY_W +: FLAG_W]};

  always_comb begin
    word = '0;
    if (active) word = {tag, slices[idx]};
  end
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
  import frame_serializer_pkg::*;
#(
  parameter int unsigned WORD_W  = DEF_WORD_W,
  parameter int unsigned N_WORDS = DEF_N_WORDS,
  parameter int unsigned FLAG_W  = DEF_FLAG_W,
  localparam int unsigned FRAME_W = frame_width(WORD_W, N_WORDS, FLAG_W),
  localparam int unsigned OUT_W   = FLAG_W + 1 + WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_sync_in,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               word_valid,
  output logic               word_first,
  output logic [OUT_W-1:0]   word_data
);
  localparam int unsigned IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

  logic [FRAME_W-1:0] frame_q;
  logic               active;
  logic [IDX_W-1:0]   idx;
  logic               at_last;
  logic               load_evt;

  assign load_evt = frame_sync_in;

  frame_hold #(.FRAME_W(FRAME_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_evt),
    .frame_in (frame_in),
    .frame_q  (frame_q)
  );

  word_sequencer #(.N_WORDS(N_WORDS)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (load_evt),
    .active  (active),
    .idx     (idx),
    .at_last (at_last)
  );

  word_assembler #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .FLAG_W(FLAG_W)) u_asm (
    .frame_q (frame_q),
    .active  (active),
    .idx     (idx),
    .word    (word_data)
  );

  assign word_valid = active;
  assign word_first = active && (idx == '0);
endmodule

// File: rtl/frame_serializer_chk.sv
module frame_serializer_chk #(
  parameter int unsigned N_WORDS = 7,
  parameter int unsigned OUT_W   = 36,
  parameter int unsigned WORD_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_sync_in,
  input logic             word_valid,
  input logic             word_first,
  input logic [OUT_W-1:0] word_data
);
  localparam int unsigned CNT_W = $clog2(N_WORDS + 1) + 1;
  logic [CNT_W-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_len <= '0;
    else if (word_first) run_len <= CNT_W'(1);
    else if (word_valid) run_len <= run_len + 1'b1;
    else                 run_len <= '0;
  end

  // R4
  sync_to_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync_in |=> word_first);

  // R6
  first_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_first |-> word_valid);

  // R5
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_first) |-> (run_len < CNT_W'(N_WORDS)));

  // R5
  run_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_valid && $past(word_valid)) |-> (run_len == CNT_W'(N_WORDS)));

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> (word_data == '0 && !word_first));

  // R2
  tag_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !word_data[OUT_W-1]);

  // R2
  tag_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_first) |-> $stable(word_data[OUT_W-1:WORD_W]));
endmodule

bind frame_serializer frame_serializer_chk #(
  .N_WORDS(N_WORDS), .OUT_W(OUT_W), .WORD_W(WORD_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_sync_in (frame_sync_in),
  .word_valid    (word_valid),
  .word_first    (word_first),
  .word_data     (word_data)
);

// File: tb/sim_frame_serializer.sv
module sim_frame_serializer;
  localparam int FW = 227;
  localparam int OW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_sync_in = 1'b0;
  logic [FW-1:0] frame_in = '0;
  logic          word_valid, word_first;
  logic [OW-1:0] word_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  frame_serializer u0 (
    .clk(clk), .rst_n(rst_n), .frame_sync_in(frame_sync_in), .frame_in(frame_in),
    .word_valid(word_valid), .word_first(word_first), .word_data(word_data)
  );

  localparam logic [FW-1:0] VEC [4] = '{
    {3'b000, 32'h7000_0007, 32'h6000_0006, 32'h5000_0005, 32'h4000_0004,
             32'h3000_0003, 32'h2000_0002, 32'h1000_0001},
    {3'b100, 32'hFFFF_0000, 32'h0000_FFFF, 32'hDEAD_BEEF, 32'hCAFE_F00D,
             32'h1234_5678, 32'h8765_4321, 32'hA5A5_5A5A},
    {3'b010, 32'h0000_0001, 32'h0000_0002, 32'h0000_0004, 32'h0000_0008,
             32'h0000_0010, 32'h0000_0020, 32'h8000_0000},
    {3'b111, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'h3333_3333,
             32'hCCCC_CCCC, 32'h0101_0101, 32'hFEFE_FEFE}
  };

  // word k: tag {0, flags[226:224]} above payload slice [32k+31:32k]
  function automatic logic [OW-1:0] exp_word(input logic [FW-1:0] f, input int k);
    logic [31:0] d;
    d = f[k*32 +: 32];
    return {1'b0, f[226], f[225], f[224], d};
  endfunction

  task automatic check(input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_word(input string req, input logic [FW-1:0] f, input int k);
    check(req, {word_valid, word_first}, {1'b1, (k == 0)});
    check(req, word_data, exp_word(f, k));
  endtask

  task automatic check_idle(input string req);
    check(req, {word_valid, word_first}, 2'b00);
    check(req, word_data, '0);
  endtask

  // drive a sync strobe; returns at the negedge showing word 0
  task automatic sync_frame(input logic [FW-1:0] f);
    frame_in = f;
    frame_sync_in = 1'b1;
    @(negedge clk);
    frame_sync_in = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R9 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R9 after reset");

    // table walk: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      sync_frame(VEC[v]);
      for (int k = 0; k < 7; k++) begin
        check_word("R3 table word", VEC[v], k);
        @(negedge clk);
      end
      check_idle("R5 valid drops after 7");
      @(negedge clk);
      check_idle("R8 idle");
    end

    // R7: restart mid-burst
    sync_frame(VEC[0]);
    for (int k = 0; k < 3; k++) begin
      check_word("R7 before restart", VEC[0], k);
      if (k < 2) @(negedge clk);
    end
    sync_frame(VEC[1]);
    for (int k = 0; k < 7; k++) begin
      check_word("R7 restarted frame", VEC[1], k);
      @(negedge clk);
    end
    check_idle("R7 idle after restart");

    // R10: frame changes without sync are ignored
    sync_frame(VEC[2]);
    check_word("R10 word0", VEC[2], 0);
    frame_in = VEC[3];
    for (int k = 1; k < 7; k++) begin
      @(negedge clk);
      frame_in = ~frame_in;
      check_word("R10 unchanged burst", VEC[2], k);
    end
    @(negedge clk);
    check_idle("R10 idle");

    // R11: sync on word 6 gives a gapless follow-on
    sync_frame(VEC[3]);
    for (int k = 0; k < 7; k++) begin
      check_word("R11 first burst", VEC[3], k);
      if (k < 6) @(negedge clk);
    end
    sync_frame(VEC[0]);
    for (int k = 0; k < 7; k++) begin
      check_word("R11 second burst", VEC[0], k);
      @(negedge clk);
    end
    check_idle("R11 idle");

    // R9: reset in the middle of a burst
    sync_frame(VEC[1]);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_idle("R9 mid-burst reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R9 stays idle");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule